// File: doc/BRIEF.md
# In-Order Load Return Sequencer

This block sits between load/store address generation and register writeback. Each cycle it may take one memory access. An access carries a tag, a size code, a signedness flag, a data-cache hit flag and the low byte offset of its address. Loads that are aligned enter a small ordered tracker. The tracker counts down each load's return latency and releases writeback strobes, with their tags, one per cycle and strictly in the order the loads were accepted.

Return latency depends on the access type. A narrow signed load is one cycle slower than other loads. Once such a load is seen, loads accepted in the cycles straight after it are also held to the slower timing. The slower timing stays in force until a cycle passes in which no load is accepted. A load that misses in the cache waits for a fill-done pulse from the refill machinery, and every younger load queues behind it.

An access of any kind whose offset does not suit its size raises a trap strobe instead of going to memory. The tracker depth is a parameter. New accesses are refused while the tracker is full.

Top module: `load_return_seq`

## Requirements
- R1: An aligned load accepted in cycle c that hits, and is not narrow-signed, raises `wbValid` with its tag in cycle c+2 when no older load is pending and the delayed mode is off.
- R2: A signed load of size code 0, 1 or 2 (byte, half, word) that hits is written back in cycle c+3.
- R3: A load accepted in the cycle straight after an accepted narrow signed load also takes three cycles. This holds for every load in an unbroken run of accepting cycles, whatever its own size or signedness.
- R4: The delayed mode ends after the first cycle with no accepted load. A fast load accepted after such a gap returns in two cycles.
- R5: A miss is held until `fillDone`. Its writeback appears in the cycle after the `fillDone` cycle, and younger hits wait behind it and are never written back before it.
- R6: An access is misaligned when its offset is not a multiple of its size. Such a load or store raises `trapValid` with its tag in cycle c+1 and never produces a writeback. Stores never produce a writeback.
- R7: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. A byte access never traps.
- R8: `issueReady` is low while DEPTH loads are outstanding. An access offered while it is low is ignored: it causes no trap and no writeback.
- R9: Loads that are ready together drain one per cycle, oldest first. Each `fillDone` pulse releases only the oldest load still waiting for a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An access is offered this cycle |
| issueReady | output | 1 | Tracker has room; the offered access is accepted |
| issueStore | input | 1 | Offered access is a store |
| issueTag | input | TAG_W | Identifier of the offered access |
| issueSize | input | 2 | Size code (0 byte, 1 half, 2 word, 3 dword) |
| issueSigned | input | 1 | Load sign-extends its data |
| issueHit | input | 1 | Data cache reports a hit |
| issueOffset | input | 3 | Byte offset of the address within a doubleword |
| fillDone | input | 1 | Refill completed for the oldest waiting miss |
| wbValid | output | 1 | Load data is written back this cycle |
| wbTag | output | TAG_W | Tag of the load written back |
| trapValid | output | 1 | Alignment trap raised this cycle |
| trapTag | output | TAG_W | Tag of the trapping access |

## Verification
The bench builds the block with a tracker depth of 4 and 4-bit tags. At that depth, four outstanding misses fill the tracker, which brings the refusal path and the drain of a full queue within a short directed sequence. Two stacked misses with separate fill pulses show that each pulse releases only the oldest waiting entry. Runs of back-to-back loads put the delayed-return mode into effect, and a single idle cycle ends it.

// File: rtl/load_return_pkg.sv
package load_return_pkg;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_HALF  = 2'd1;
  localparam logic [1:0] SZ_WORD  = 2'd2;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic push;   // enqueue the offered load
    logic pop;    // head entry leaves this cycle
    logic slow;   // enqueued load takes the three-cycle return
    logic trap;   // offered access is misaligned
  } strobe_t;

  function automatic logic isMisaligned(input logic [1:0] sz, input logic [2:0] off);
    case (sz)
      SZ_HALF:  return off[0];
      SZ_WORD:  return |off[1:0];
      SZ_DWORD: return |off;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/load_return_ctrl.sv
module load_return_ctrl
  import load_return_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             issueStore,
  input  logic [1:0]       issueSize,
  input  logic             issueSigned,
  input  logic [2:0]       issueOffset,
  input  logic             headReady,
  output logic             issueReady,
  output strobe_t          stb,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx
);

  logic [CNT_W-1:0] count;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             delayMode;
  logic             accept, misaligned, narrowSigned, loadGo;

  assign issueReady   = (count != CNT_W'(DEPTH));
  assign accept       = issueValid && issueReady;
  assign misaligned   = isMisaligned(issueSize, issueOffset);
  assign narrowSigned = issueSigned && (issueSize != SZ_DWORD);
  assign loadGo       = accept && !issueStore && !misaligned;

  always_comb begin
    stb.push = loadGo;
    stb.pop  = headReady;
    stb.slow = narrowSigned || delayMode;
    stb.trap = accept && misaligned;
  end

  assign wrIdx = wrPtr;
  assign rdIdx = rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      delayMode <= 1'b0;
    end else begin
      count <= count + CNT_W'(stb.push) - CNT_W'(stb.pop);
      if (stb.push) wrPtr <= wrPtr + 1'b1;
      if (stb.pop)  rdPtr <= rdPtr + 1'b1;
      // mode persists across back-to-back loads, drops after an idle cycle
      delayMode <= loadGo ? (delayMode || narrowSigned) : 1'b0;
    end
  end

endmodule

// File: rtl/load_return_dp.sv
module load_return_dp
  import load_return_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [PTR_W-1:0] wrIdx,
  input  logic [PTR_W-1:0] rdIdx,
  input  logic [TAG_W-1:0] inTag,
  input  logic             inHit,
  input  logic             fillDone,
  output logic             headReady,
  output logic [TAG_W-1:0] headTag,
  output logic             trapValid,
  output logic [TAG_W-1:0] trapTag
);

  logic [DEPTH-1:0] vld, waitFill, fillSel;
  logic [1:0]       cnt  [DEPTH];
  logic [TAG_W-1:0] tagQ [DEPTH];
  logic [PTR_W-1:0] scanIdx;
  logic             found;

  // oldest entry still waiting for a fill, searched from the head
  always_comb begin
    fillSel = '0;
    found   = 1'b0;
    scanIdx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      scanIdx = rdIdx + PTR_W'(k);
      if (!found && vld[scanIdx] && waitFill[scanIdx]) begin
        fillSel[scanIdx] = 1'b1;
        found = 1'b1;
      end
    end
  end

  assign headReady = vld[rdIdx] && (cnt[rdIdx] == 2'd0) && !waitFill[rdIdx];
  assign headTag   = tagQ[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld      <= '0;
      waitFill <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        cnt[i]  <= 2'd0;
        tagQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (stb.push && wrIdx == PTR_W'(i)) begin
          vld[i]      <= 1'b1;
          tagQ[i]     <= inTag;
          cnt[i]      <= stb.slow ? 2'd2 : 2'd1;
          waitFill[i] <= !inHit;
        end else begin
          if (stb.pop && rdIdx == PTR_W'(i)) vld[i] <= 1'b0;
          if (cnt[i] != 2'd0) cnt[i] <= cnt[i] - 2'd1;
          if (fillDone && fillSel[i]) waitFill[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapValid <= 1'b0;
      trapTag   <= '0;
    end else begin
      trapValid <= stb.trap;
      if (stb.trap) trapTag <= inTag;
    end
  end

endmodule

// File: rtl/load_return_seq.sv
module load_return_seq
  import load_return_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  output logic             issueReady,
  input  logic             issueStore,
  input  logic [TAG_W-1:0] issueTag,
  input  logic [1:0]       issueSize,
  input  logic             issueSigned,
  input  logic             issueHit,
  input  logic [2:0]       issueOffset,
  input  logic             fillDone,
  output logic             wbValid,
  output logic [TAG_W-1:0] wbTag,
  output logic             trapValid,
  output logic [TAG_W-1:0] trapTag
);

  localparam int PTR_W = $clog2(DEPTH);

  strobe_t          stb;
  logic [PTR_W-1:0] wrIdx, rdIdx;
  logic             headReady;

  load_return_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueStore(issueStore),
    .issueSize(issueSize), .issueSigned(issueSigned),
    .issueOffset(issueOffset), .headReady(headReady),
    .issueReady(issueReady), .stb(stb),
    .wrIdx(wrIdx), .rdIdx(rdIdx)
  );

  load_return_dp #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrIdx(wrIdx), .rdIdx(rdIdx),
    .inTag(issueTag), .inHit(issueHit), .fillDone(fillDone),
    .headReady(headReady), .headTag(wbTag),
    .trapValid(trapValid), .trapTag(trapTag)
  );

  assign wbValid = headReady;

endmodule

// File: rtl/load_return_chk.sv
module load_return_chk
  import load_return_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       issueValid,
  input logic       issueReady,
  input logic       issueStore,
  input logic [1:0] issueSize,
  input logic [2:0] issueOffset,
  input logic       wbValid,
  input logic       trapValid
);

  localparam int OW = $clog2(DEPTH) + 2;

  logic [OW-1:0] outstanding;
  logic          accLoad;

  assign accLoad = issueValid && issueReady && !issueStore &&
                   !isMisaligned(issueSize, issueOffset);

  always_ff @(posedge clk) begin
    if (!rstN) outstanding <= '0;
    else       outstanding <= outstanding + OW'(accLoad) - OW'(wbValid);
  end

  p_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    outstanding <= OW'(DEPTH));

  p_ready_room_r8: assert property (@(posedge clk) disable iff (!rstN)
    issueReady == (outstanding < OW'(DEPTH)));

  p_min_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    (outstanding == '0 && accLoad) |=> !wbValid);

  p_wb_has_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> outstanding != '0);

  p_trap_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> $past(issueValid && issueReady && isMisaligned(issueSize, issueOffset)));

endmodule

bind load_return_seq load_return_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(issueReady),
  .issueStore(issueStore), .issueSize(issueSize), .issueOffset(issueOffset),
  .wbValid(wbValid), .trapValid(trapValid)
);

// File: tb/tb_load_return_seq.sv
`timescale 1ns/100ps
module tb_load_return_seq;

  localparam int DEPTH = 4;
  localparam int TAG_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             issueValid = 1'b0, issueStore = 1'b0, issueSigned = 1'b0;
  logic             issueHit = 1'b1, fillDone = 1'b0;
  logic [TAG_W-1:0] issueTag = '0;
  logic [1:0]       issueSize = '0;
  logic [2:0]       issueOffset = '0;
  logic             issueReady, wbValid, trapValid;
  logic [TAG_W-1:0] wbTag, trapTag;

  int checks = 0, fails = 0, cyc = 0;
  int wbN = 0, trapN = 0;
  int wbTagLog [16], wbCycLog [16], trapTagLog [16], trapCycLog [16];

  load_return_seq #(.DEPTH(DEPTH), .TAG_W(TAG_W)) dut (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (wbValid && wbN < 16) begin
      wbTagLog[wbN] = int'(wbTag); wbCycLog[wbN] = cyc; wbN++;
    end
    if (trapValid && trapN < 16) begin
      trapTagLog[trapN] = int'(trapTag); trapCycLog[trapN] = cyc; trapN++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expectWb(input int i, input int tag, input int c, input string req);
    chk(wbN > i && wbTagLog[i] == tag, {req, " wb tag"}, (wbN > i) ? wbTagLog[i] : -1, tag);
    chk(wbN > i && wbCycLog[i] == c, {req, " wb cycle"}, (wbN > i) ? wbCycLog[i] : -1, c);
  endtask

  task automatic expectTrap(input int i, input int tag, input int c, input string req);
    chk(trapN > i && trapTagLog[i] == tag && trapCycLog[i] == c, {req, " trap tag/cycle"},
        (trapN > i) ? trapTagLog[i] * 1000 + trapCycLog[i] : -1, tag * 1000 + c);
  endtask

  task automatic clearLogs();
    @(posedge clk);
    wbN = 0; trapN = 0;
  endtask

  task automatic issueOne(input int tag, input logic [1:0] sz, input bit sgn, input bit hit,
                          input int off, input bit st, output int c);
    @(negedge clk);
    issueValid = 1'b1; issueTag = TAG_W'(tag); issueSize = sz; issueSigned = sgn;
    issueHit = hit; issueOffset = 3'(off); issueStore = st; fillDone = 1'b0;
    c = cyc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      issueValid = 1'b0; fillDone = 1'b0; issueStore = 1'b0;
    end
  endtask

  task automatic fill(output int f);
    @(negedge clk);
    issueValid = 1'b0; fillDone = 1'b1;
    f = cyc;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(issueReady == 1'b1, "R8 reset ready", int'(issueReady), 1);
    chk(wbValid == 1'b0, "R1 reset wb", int'(wbValid), 0);
    chk(trapValid == 1'b0, "R6 reset trap", int'(trapValid), 0);
  endtask

  task automatic testFast();
    int c1, c2;
    clearLogs();
    issueOne(1, 2'd2, 1'b0, 1'b1, 4, 1'b0, c1);   // unsigned word
    issueOne(2, 2'd3, 1'b1, 1'b1, 0, 1'b0, c2);   // signed dword stays fast
    idle(5);
    expectWb(0, 1, c1 + 2, "R1");
    expectWb(1, 2, c2 + 2, "R1");
    chk(wbN == 2, "R1 wb count", wbN, 2);
  endtask

  task automatic testSlow();
    int c1;
    clearLogs();
    issueOne(3, 2'd1, 1'b1, 1'b1, 2, 1'b0, c1);   // signed half
    idle(5);
    expectWb(0, 3, c1 + 3, "R2");
  endtask

  task automatic testDelayMode();
    int c1, c2, c3, c4;
    clearLogs();
    issueOne(4, 2'd0, 1'b1, 1'b1, 1, 1'b0, c1);   // signed byte: slow
    issueOne(5, 2'd2, 1'b0, 1'b1, 0, 1'b0, c2);   // delayed by mode
    issueOne(6, 2'd3, 1'b0, 1'b1, 0, 1'b0, c3);   // still in the run
    idle(1);
    issueOne(7, 2'd2, 1'b0, 1'b1, 0, 1'b0, c4);   // after a gap: fast
    idle(6);
    expectWb(0, 4, c1 + 3, "R2");
    expectWb(1, 5, c2 + 3, "R3");
    expectWb(2, 6, c3 + 3, "R3");
    expectWb(3, 7, c4 + 2, "R4");
  endtask

  task automatic testMiss();
    int c1, c2, c3, f;
    clearLogs();
    issueOne(8, 2'd2, 1'b0, 1'b0, 0, 1'b0, c1);   // miss
    issueOne(9, 2'd2, 1'b0, 1'b1, 0, 1'b0, c2);
    issueOne(10, 2'd2, 1'b0, 1'b1, 0, 1'b0, c3);
    idle(6);
    chk(wbN == 0, "R5 hits held behind miss", wbN, 0);
    fill(f);
    idle(6);
    expectWb(0, 8, f + 1, "R5");
    expectWb(1, 9, f + 2, "R9");
    expectWb(2, 10, f + 3, "R9");
  endtask

  task automatic testTwoMisses();
    int c1, c2, c3, f1, f2;
    clearLogs();
    issueOne(11, 2'd2, 1'b0, 1'b0, 0, 1'b0, c1);
    issueOne(12, 2'd2, 1'b0, 1'b0, 0, 1'b0, c2);
    issueOne(13, 2'd2, 1'b0, 1'b1, 0, 1'b0, c3);
    idle(4);
    fill(f1);
    idle(3);
    chk(wbN == 1, "R9 one fill releases one miss", wbN, 1);
    fill(f2);
    idle(5);
    expectWb(0, 11, f1 + 1, "R9");
    expectWb(1, 12, f2 + 1, "R9");
    expectWb(2, 13, f2 + 2, "R5");
  endtask

  task automatic testTrap();
    int c0, c1, c2, c3, c4, c5;
    clearLogs();
    issueOne(14, 2'd1, 1'b0, 1'b1, 1, 1'b0, c0);  // odd half
    issueOne(15, 2'd2, 1'b0, 1'b1, 2, 1'b0, c1);  // word at 2
    issueOne(1, 2'd0, 1'b1, 1'b1, 3, 1'b0, c2);   // byte: never traps
    issueOne(2, 2'd3, 1'b0, 1'b1, 4, 1'b0, c3);   // dword at 4
    issueOne(3, 2'd2, 1'b0, 1'b1, 6, 1'b1, c4);   // misaligned store
    issueOne(4, 2'd2, 1'b0, 1'b1, 0, 1'b1, c5);   // aligned store
    idle(6);
    expectTrap(0, 14, c0 + 1, "R6");
    expectTrap(1, 15, c1 + 1, "R6");
    expectTrap(2, 2, c3 + 1, "R6");
    expectTrap(3, 3, c4 + 1, "R6");
    chk(trapN == 4, "R7 byte access no trap", trapN, 4);
    expectWb(0, 1, c2 + 3, "R7");  // signed byte: slow return
    chk(wbN == 1, "R6 no wb for traps or stores", wbN, 1);
  endtask

  task automatic testFull();
    int c, f;
    clearLogs();
    for (int t = 1; t <= 4; t++) issueOne(t, 2'd2, 1'b0, 1'b0, 0, 1'b0, c);
    issueOne(5, 2'd2, 1'b0, 1'b1, 0, 1'b0, c);
    chk(issueReady == 1'b0, "R8 ready low when full", int'(issueReady), 0);
    issueOne(6, 2'd1, 1'b0, 1'b1, 1, 1'b0, c);
    idle(4);
    chk(trapN == 0, "R8 refused access no trap", trapN, 0);
    chk(wbN == 0, "R8 nothing written back yet", wbN, 0);
    fill(f);
    for (int i = 0; i < 3; i++) fill(c);
    idle(5);
    for (int i = 0; i < 4; i++) expectWb(i, i + 1, f + 1 + i, "R9");
    chk(wbN == 4, "R8 refused load never written back", wbN, 4);
    chk(issueReady == 1'b1, "R8 ready after drain", int'(issueReady), 1);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(5ns * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(4);
    testReset();
    @(negedge clk) rstN = 1'b1;
    idle(2);
    testReset();
    testFast();
    testSlow();
    testDelayMode();
    testMiss();
    testTwoMisses();
    testTrap();
    testFull();
    finishRun();
  end

endmodule